// File: doc/BRIEF.md
# NAND Erase-Block Sweeper with Factory-Mark Protection

This block sweeps an inclusive range of erase blocks on a NAND device, one block at a time, through a downstream flash bus controller. For every block it first fetches the spare (out-of-band) bytes of the block's first page. It then decides whether the block carries a factory bad mark. A marked block is left untouched so that its mark survives. An unmarked block is erased. After a good erase, the block gets a fixed cleanmarker pattern programmed into the spare area of its first page. The data area is never written.

The controller side uses a single operation channel: a request with an operation code and a block number, held until accepted. Spare bytes arrive as a byte stream on a read port. Spare bytes for programming leave through a byte stream with backpressure. Each operation ends with one completion beat carrying a pass/fail bit. The controller must deliver that completion at least one cycle after the last read byte.

A static page-size input selects the spare layout. Small-page devices use 8 spare bytes and a 2-byte cleanmarker. Large-page devices use 16 spare bytes and an 8-byte cleanmarker. The block reports how many blocks were erased and how many were skipped, counts failed blocks, and raises a sticky failure flag.

Top module: `nbs_erase_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `op_valid`, `wr_valid` and `any_fail` are 0, and all three counters are 0.
- R2: A `start` pulse while idle latches `first_blk`/`last_blk`, clears the counters and `any_fail`, and visits blocks upward from `first_blk` through `last_blk` inclusive, with exactly the operations R3–R6 call for. If `last_blk < first_blk`, only `first_blk` is visited. A `start` while busy has no effect on the sweep.
- R3: Each visited block begins with a spare read of its first page (`op_code` 2'b00). Spare bytes arrive in index order starting at 0 on `rd_valid`/`rd_data`. Only the byte at index 5 decides the bad test.
- R4: A block whose index-5 spare byte has any bit at 0 gets neither an erase nor a program operation, and `skipped_cnt` increments by one.
- R5: An unmarked block with a passing read is erased (`op_code` 2'b01). If the erase passes, `erased_cnt` increments and a spare program of the first page follows (`op_code` 2'b10).
- R6: A failed spare read or a failed erase increments `failed_cnt` and sets `any_fail`, and no program follows for that block.
- R7: Programmed spare data is 8 bytes when `big_page`=0 and 16 bytes when `big_page`=1, sent in index order from 0. Small-page devices get index 6 = 0x85 and index 7 = 0x19. Large-page devices get indices 8..15 = 0x85, 0x19, 0x03, 0x20, 0x08, 0x00, 0x00, 0x00. Every other index is 0xFF.
- R8: A failed program sets `any_fail` and leaves all three counters unchanged.
- R9: `op_valid` keeps `op_code`/`op_blk` stable until `op_ready`. `wr_valid` keeps `wr_data` stable until `wr_ready`. An operation request and a write byte are never offered in the same cycle.
- R10: When the last block finishes, `done` pulses for exactly one cycle, and `busy` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep (sampled only when idle) |
| big_page | input | 1 | Static layout select: 0 = 8-byte spare, 1 = 16-byte spare |
| first_blk | input | BLK_W | First block of the range |
| last_blk | input | BLK_W | Last block of the range |
| op_valid | output | 1 | Operation request valid |
| op_ready | input | 1 | Controller accepts the request |
| op_code | output | 2 | 00 spare read, 01 erase, 10 spare program |
| op_blk | output | BLK_W | Target block number |
| rd_valid | input | 1 | Spare read byte valid |
| rd_data | input | 8 | Spare read byte |
| wr_valid | output | 1 | Spare program byte valid |
| wr_ready | input | 1 | Controller takes the program byte |
| wr_data | output | 8 | Spare program byte |
| rsp_valid | input | 1 | Operation completion beat |
| rsp_ok | input | 1 | Completion result, 1 = pass |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| erased_cnt | output | CNT_W | Blocks erased successfully |
| skipped_cnt | output | CNT_W | Blocks skipped as factory-marked |
| failed_cnt | output | CNT_W | Blocks whose read or erase failed |
| any_fail | output | 1 | Sticky flag for any read, erase or program failure |

## Verification
Faults inside the block become visible at the ports within one operation. A wrong block counter, a misread mark byte or a wrong branch after a completion each produce the wrong next request on the operation channel. The reference model flags that mismatch in the same cycle the request is offered. A bad stream index or a wrong layout select corrupts a specific spare byte, and the mismatch appears on the very handshake that carries it. Counter and flag faults surface in the totals read when `done` pulses.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    OP_RDSPARE   = 2'd0,
    OP_ERASE     = 2'd1,
    OP_PROGSPARE = 2'd2
  } nbs_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RDREQ,
    S_RDWAIT,
    S_ERREQ,
    S_ERWAIT,
    S_PGREQ,
    S_PGDATA,
    S_PGWAIT,
    S_NEXT
  } nbs_state_e;

  // position of the factory mark byte inside the first-page spare area
  localparam int MARK_IDX  = 5;
  localparam int SPB_SMALL = 8;
  localparam int SPB_BIG   = 16;
  localparam int IDX_W     = $clog2(SPB_BIG);

  // tally slots
  localparam int T_ERASED = 0;
  localparam int T_SKIP   = 1;
  localparam int T_FAIL   = 2;
  localparam int T_NUM    = 3;
endpackage

// File: rtl/nbs_badcheck.sv
module nbs_badcheck #(
  parameter int IDX_W    = 4,
  parameter int MARK_IDX = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rd_valid,
  input  logic [7:0] rd_data,
  output logic       is_bad
);
  localparam logic [IDX_W-1:0] MARK_POS = IDX_W'(MARK_IDX);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bad_q, bad_d;

  always_comb begin
    idx_d = idx_q;
    bad_d = bad_q;
    if (clr) begin
      idx_d = '0;
      bad_d = 1'b0;
    end else if (rd_valid) begin
      if (idx_q == MARK_POS) bad_d = (rd_data != 8'hFF);
      if (idx_q != '1) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      bad_q <= bad_d;
    end
  end

  assign is_bad = bad_q;
endmodule

// File: rtl/nbs_marker_gen.sv
module nbs_marker_gen #(
  parameter int IDX_W = 4
) (
  input  logic             big_page,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       data
);
  // large-page pattern, byte k of the pattern at bits [8k +: 8]
  localparam logic [63:0] BIG_PAT   = 64'h0000_0008_2003_1985;
  localparam int          BIG_BASE  = 8;
  localparam logic [15:0] SML_PAT   = 16'h1985;
  localparam int          SML_BASE  = 6;

  logic [IDX_W-1:0] big_off, sml_off;

  assign big_off = idx - IDX_W'(BIG_BASE);
  assign sml_off = idx - IDX_W'(SML_BASE);

  always_comb begin
    data = 8'hFF;
    if (big_page) begin
      if (idx >= IDX_W'(BIG_BASE) && big_off < IDX_W'(8))
        data = BIG_PAT[{big_off[2:0], 3'b000} +: 8];
    end else begin
      if (idx >= IDX_W'(SML_BASE) && sml_off < IDX_W'(2))
        data = SML_PAT[{sml_off[0], 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/nbs_tally.sv
module nbs_tally #(
  parameter int W = 11,
  parameter int N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [N-1:0]      inc,
  output logic [N-1:0][W-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] c_q, c_d;
    logic         c_en;

    assign c_en = clr | inc[g];
    assign c_d  = clr ? '0 : c_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    c_q <= '0;
      else if (c_en) c_q <= c_d;
    end

    assign cnt[g] = c_q;
  end
endmodule

// File: rtl/nbs_erase_walker.sv
module nbs_erase_walker
  import nbs_pkg::*;
#(
  parameter int BLK_W = 10,
  parameter int CNT_W = BLK_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             big_page,
  input  logic [BLK_W-1:0] first_blk,
  input  logic [BLK_W-1:0] last_blk,
  output logic             op_valid,
  input  logic             op_ready,
  output logic [1:0]       op_code,
  output logic [BLK_W-1:0] op_blk,
  input  logic             rd_valid,
  input  logic [7:0]       rd_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [7:0]       wr_data,
  input  logic             rsp_valid,
  input  logic             rsp_ok,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] erased_cnt,
  output logic [CNT_W-1:0] skipped_cnt,
  output logic [CNT_W-1:0] failed_cnt,
  output logic             any_fail
);
  localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'(SPB_SMALL - 1);
  localparam logic [IDX_W-1:0] LAST_BIG   = IDX_W'(SPB_BIG - 1);

  nbs_state_e       state_q, state_d;
  logic [BLK_W-1:0] cur_q, cur_d, last_q, last_d;
  logic             blk_en;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             fail_q, fail_d;
  logic             done_q, done_d;
  logic [T_NUM-1:0] inc;
  logic             clr_cnt;
  logic             sc_clr;
  logic             is_bad;
  logic [IDX_W-1:0] idx_last;
  logic [T_NUM-1:0][CNT_W-1:0] tally;

  assign idx_last = big_page ? LAST_BIG : LAST_SMALL;

  nbs_badcheck #(.IDX_W(IDX_W), .MARK_IDX(MARK_IDX)) u_bad (
    .clk(clk), .rst_n(rst_n), .clr(sc_clr),
    .rd_valid(rd_valid), .rd_data(rd_data), .is_bad(is_bad)
  );

  nbs_marker_gen #(.IDX_W(IDX_W)) u_mark (
    .big_page(big_page), .idx(idx_q), .data(wr_data)
  );

  nbs_tally #(.W(CNT_W), .N(T_NUM)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(inc), .cnt(tally)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    last_d  = last_q;
    blk_en  = 1'b0;
    idx_d   = idx_q;
    fail_d  = fail_q;
    done_d  = 1'b0;
    inc     = '0;
    clr_cnt = 1'b0;
    sc_clr  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          cur_d   = first_blk;
          last_d  = last_blk;
          blk_en  = 1'b1;
          fail_d  = 1'b0;
          clr_cnt = 1'b1;
          state_d = S_RDREQ;
        end
      end
      S_RDREQ: begin
        sc_clr = 1'b1;
        if (op_ready) state_d = S_RDWAIT;
      end
      S_RDWAIT: begin
        if (rsp_valid) begin
          if (!rsp_ok) begin
            inc[T_FAIL] = 1'b1;
            fail_d      = 1'b1;
            state_d     = S_NEXT;
          end else if (is_bad) begin
            inc[T_SKIP] = 1'b1;
            state_d     = S_NEXT;
          end else begin
            state_d = S_ERREQ;
          end
        end
      end
      S_ERREQ: begin
        if (op_ready) state_d = S_ERWAIT;
      end
      S_ERWAIT: begin
        if (rsp_valid) begin
          if (rsp_ok) begin
            inc[T_ERASED] = 1'b1;
            state_d       = S_PGREQ;
          end else begin
            inc[T_FAIL] = 1'b1;
            fail_d      = 1'b1;
            state_d     = S_NEXT;
          end
        end
      end
      S_PGREQ: begin
        idx_d = '0;
        if (op_ready) state_d = S_PGDATA;
      end
      S_PGDATA: begin
        if (wr_ready) begin
          if (idx_q == idx_last) state_d = S_PGWAIT;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      S_PGWAIT: begin
        if (rsp_valid) begin
          if (!rsp_ok) fail_d = 1'b1;
          state_d = S_NEXT;
        end
      end
      S_NEXT: begin
        if (cur_q >= last_q) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          cur_d   = cur_q + 1'b1;
          blk_en  = 1'b1;
          state_d = S_RDREQ;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      last_q <= '0;
    end else if (blk_en) begin
      cur_q  <= cur_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    op_valid = 1'b0;
    op_code  = OP_RDSPARE;
    unique case (state_q)
      S_RDREQ: begin op_valid = 1'b1; op_code = OP_RDSPARE;   end
      S_ERREQ: begin op_valid = 1'b1; op_code = OP_ERASE;     end
      S_PGREQ: begin op_valid = 1'b1; op_code = OP_PROGSPARE; end
      default: ;
    endcase
  end

  assign op_blk      = cur_q;
  assign wr_valid    = (state_q == S_PGDATA);
  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign any_fail    = fail_q;
  assign erased_cnt  = tally[T_ERASED];
  assign skipped_cnt = tally[T_SKIP];
  assign failed_cnt  = tally[T_FAIL];
endmodule

// File: rtl/nbs_erase_walker_chk.sv
module nbs_erase_walker_chk #(
  parameter int BLK_W = 10,
  parameter int CNT_W = BLK_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_code,
  input logic [BLK_W-1:0] op_blk,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [7:0]       wr_data,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] erased_cnt,
  input logic [CNT_W-1:0] skipped_cnt,
  input logic [CNT_W-1:0] failed_cnt,
  input logic             any_fail
);
  assert_op_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_code) && $stable(op_blk));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && wr_valid));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !op_valid && !wr_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(erased_cnt) && $stable(skipped_cnt)
                         && $stable(failed_cnt) && $stable(any_fail));

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> op_code != 2'b11);
endmodule

bind nbs_erase_walker nbs_erase_walker_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/nbs_erase_walker_test.sv
module nbs_erase_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 10;
  localparam int CW = BW + 1;
  localparam int NB = 64;

  logic          clk, rst_n, start, big_page;
  logic [BW-1:0] first_blk, last_blk, op_blk;
  logic          op_valid, op_ready, rd_valid, wr_valid, wr_ready, rsp_valid, rsp_ok;
  logic [1:0]    op_code;
  logic [7:0]    rd_data, wr_data;
  logic          busy, done, any_fail;
  logic [CW-1:0] erased_cnt, skipped_cnt, failed_cnt;

  nbs_erase_walker #(.BLK_W(BW), .CNT_W(CW)) uut (.*);

  int nvec = 0, nerr = 0;
  bit finished = 0;

  logic [7:0] mark [NB];
  bit rd_fail [NB];
  bit er_fail [NB];
  bit pg_fail [NB];
  int q_code[$];
  int q_blk[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] spare_byte(input int b, input int i);
    if (i == 5) return mark[b];
    if (i == 4) return 8'h00;   // non-mark byte that must not matter
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_mark(input bit m, input int i);
    if (!m) begin
      if (i == 6) return 8'h85;
      if (i == 7) return 8'h19;
      return 8'hFF;
    end
    case (i)
      8: return 8'h85;
      9: return 8'h19;
      10: return 8'h03;
      11: return 8'h20;
      12: return 8'h08;
      13, 14, 15: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // controller model: reacts at the falling edge, effective at the next rising edge
  initial begin : responder
    int ph, cnt, wcnt, pblk, hold, spb;
    bit ok, wr_rdy;
    ph = 0; cnt = 0; wcnt = 0; pblk = 0; hold = 0; ok = 0;
    op_ready = 0; rd_valid = 0; rd_data = 8'hFF; wr_ready = 0; rsp_valid = 0; rsp_ok = 0;
    forever begin
      @(negedge clk);
      op_ready = 0; rd_valid = 0; rd_data = 8'hFF; wr_ready = 0; rsp_valid = 0; rsp_ok = 0;
      spb = big_page ? 16 : 8;
      if (!rst_n) begin
        ph = 0; hold = 0;
      end else begin
        case (ph)
          0: if (op_valid) begin
               if (hold == 0) hold = 1;      // one stall cycle per request
               else begin
                 hold = 0;
                 op_ready = 1;
                 if (q_code.size() == 0) begin
                   check(0, "R2", "unexpected op", op_code, 3);
                 end else begin
                   check(op_code == 2'(q_code[0]), "R3 R4 R5 R6", "op code", op_code, q_code[0]);
                   check(op_blk == BW'(q_blk[0]), "R2", "op block", op_blk, q_blk[0]);
                   void'(q_code.pop_front());
                   void'(q_blk.pop_front());
                 end
                 pblk = int'(op_blk);
                 cnt = 0; wcnt = 0;
                 ph = (op_code == 2'd0) ? 1 : (op_code == 2'd1) ? 2 : 3;
               end
             end
          1: begin
               rd_valid = 1; rd_data = spare_byte(pblk, cnt); cnt++;
               if (cnt == spb) begin ph = 4; ok = !rd_fail[pblk]; end
             end
          2: begin
               cnt++;
               if (cnt == 3) begin ph = 4; ok = !er_fail[pblk]; end
             end
          3: begin
               wr_rdy = (cnt % 3) != 1;
               wr_ready = wr_rdy;
               cnt++;
               if (wr_valid && wr_rdy) begin
                 check(wr_data == exp_mark(big_page, wcnt), "R7", $sformatf("spare byte %0d", wcnt),
                       wr_data, exp_mark(big_page, wcnt));
                 wcnt++;
                 if (wcnt == spb) begin ph = 4; ok = !pg_fail[pblk]; end
               end
             end
          default: begin
               rsp_valid = 1; rsp_ok = ok; ph = 0;
             end
        endcase
      end
    end
  end

  task automatic run(input int f, input int l, input bit m, input bit repulse, input string tag);
    int er, sk, fl, guard;
    bit af, seen;
    er = 0; sk = 0; fl = 0; af = 0; seen = 0;
    for (int b = f; ; b++) begin
      q_code.push_back(0); q_blk.push_back(b);
      if (rd_fail[b]) fl++;
      else if (mark[b] != 8'hFF) sk++;
      else begin
        q_code.push_back(1); q_blk.push_back(b);
        if (er_fail[b]) fl++;
        else begin
          er++;
          q_code.push_back(2); q_blk.push_back(b);
          if (pg_fail[b]) af = 1;
        end
      end
      if (b >= l) break;
    end
    if (fl > 0) af = 1;
    @(negedge clk);
    big_page = m; first_blk = BW'(f); last_blk = BW'(l); start = 1;
    @(negedge clk);
    start = 0;
    if (repulse) begin
      repeat (12) @(negedge clk);
      first_blk = BW'(50); last_blk = BW'(60); start = 1;   // R2: ignored while busy
      @(negedge clk);
      start = 0;
    end
    guard = 0;
    while (!seen && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (done) seen = 1;
    end
    check(seen, "R10", {tag, " done seen"}, seen, 1);
    check(!busy, "R10", {tag, " busy low with done"}, busy, 0);
    check(erased_cnt == CW'(er), "R5", {tag, " erased count"}, erased_cnt, er);
    check(skipped_cnt == CW'(sk), "R4", {tag, " skipped count"}, skipped_cnt, sk);
    check(failed_cnt == CW'(fl), "R6", {tag, " failed count"}, failed_cnt, fl);
    check(any_fail == af, "R6 R8", {tag, " any_fail"}, any_fail, af);
    check(q_code.size() == 0, "R2", {tag, " ops left"}, q_code.size(), 0);
    @(negedge clk);
    check(!done, "R10", {tag, " done one cycle"}, done, 0);
    q_code.delete(); q_blk.delete();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0; start = 0; big_page = 0; first_blk = '0; last_blk = '0;
    for (int b = 0; b < NB; b++) begin
      mark[b] = 8'hFF; rd_fail[b] = 0; er_fail[b] = 0; pg_fail[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !op_valid && !wr_valid, "R1", "idle outputs",
          {busy, done, op_valid, wr_valid}, 0);
    check(erased_cnt == 0 && skipped_cnt == 0 && failed_cnt == 0 && !any_fail, "R1",
          "counters", erased_cnt + skipped_cnt + failed_cnt + any_fail, 0);

    // small page, mixed marks (one zero bit suffices), one erase failure
    mark[3] = 8'h00; mark[5] = 8'h7F; mark[8] = 8'hFE; er_fail[6] = 1;
    run(2, 9, 1'b0, 1'b0, "small-page sweep");

    // large page: bad, read fail, erase fail, program fail (R8)
    mark[11] = 8'hEF; rd_fail[12] = 1; er_fail[13] = 1; pg_fail[14] = 1;
    run(10, 15, 1'b1, 1'b0, "large-page sweep");

    // single block range
    run(20, 20, 1'b1, 1'b0, "single block");

    // reversed range visits first only
    run(30, 25, 1'b0, 1'b0, "reversed range");

    // start while busy has no effect
    mark[42] = 8'h80;
    run(40, 44, 1'b0, 1'b1, "restart ignored");

    // clean run after failures clears the flag (R2)
    run(45, 46, 1'b1, 1'b0, "flag cleared");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule